// File: doc/BRIEF.md
# Inclusive Last-Level Cache Coherence Controller with Presence Filtering

This block sits between a few private core caches and a small shared last-level cache (LLC). It handles whole-line requests from the cores. Each LLC entry keeps one presence bit per core. A set bit means that core may hold the line. Because every line a core holds is also kept in the LLC, the tag lookup by itself tells the controller who could own a copy.

A lookup ends in one of three ways:
- A miss goes straight to memory with no snoops.
- A hit marked only for the requester, or for no core, is answered from the LLC.
- A hit marked for other cores snoops exactly those cores, and no one else.

Read requests downgrade the other holders. Ownership (write) requests invalidate them. When a snoop returns modified data, that data is written into the LLC before it is forwarded. Responses to request snoops are counted as clean or dirty.

When an allocation needs a valid way, the controller first back-invalidates every core marked in that way. It then writes the victim back if it is dirty. Only after that is the new line fetched. One transaction is in flight at a time.

Top module: `llc_snoop_filter`

## Requirements
- R1: After reset, no core sees a request grant or a response, no snoop is driven, no memory request is driven, and both snoop counters read zero.
- R2: A request whose line is absent from the LLC issues exactly one memory read of the requested line address. No core is snooped. The response returns the memory data.
- R3: A request that hits a line whose presence mask holds only the requester, or no core, is answered from the LLC. It causes no snoop and no memory access.
- R4: A read that hits a line marked for other cores sends a non-invalidating snoop (snp_inv_o = 0) to each marked core except the requester, and to no other core. Afterwards the requester's presence bit is added to the mask.
- R5: A write (ownership) request that hits a line marked for other cores sends an invalidating snoop (snp_inv_o = 1) to each of them. Afterwards the mask holds only the requester's bit.
- R6: When a snooped core acknowledges with snp_dirty_i = 1, its snp_data_i line is stored in the LLC and returned to the requester. Later hits are served with that data, and evicting the line writes it back to memory.
- R7: Each acknowledged snoop issued for a core request adds one to clean_cnt_o (snp_dirty_i = 0) or to dirty_cnt_o (snp_dirty_i = 1). Back-invalidate snoops change neither counter.
- R8: Allocating over a valid way first sends an invalidating snoop to every core in that way's mask, using the victim's address. If the victim is dirty, or a snoop returned modified data, the victim is then written to memory at its own address. The new line is read only after that.
- R9: Only one transaction is in flight. Among requests pending together, the lowest-numbered core is granted first. Every other request, including one to the same line, waits until the previous response has been sent.
- R10: Inclusion holds. A memory fill is never issued for a line that any core's private cache still holds.
- R11: Victim choice within a set: the lowest-numbered invalid way is used first. If no way is invalid, a per-set round-robin pointer is used, and it advances on every allocation in that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | N_CORES | Per-core request valid, held until granted |
| req_write_i | input | N_CORES | Per-core request kind: 1 = ownership, 0 = read |
| req_addr_i | input | N_CORES*ADDR_W | Per-core line address, core c in bits [c*ADDR_W +: ADDR_W] |
| req_ready_o | output | N_CORES | One-hot grant; a request is taken when valid and ready are both high |
| resp_valid_o | output | N_CORES | One-cycle response strobe to the requesting core |
| resp_data_o | output | DATA_W | Line data returned with the response |
| snp_valid_o | output | N_CORES | Per-core snoop request, held until that core acknowledges |
| snp_inv_o | output | 1 | 1 = invalidate the line, 0 = downgrade to shared |
| snp_addr_o | output | ADDR_W | Line address of the current snoop |
| snp_ack_i | input | N_CORES | Per-core one-cycle snoop acknowledge |
| snp_dirty_i | input | N_CORES | With acknowledge: the core returns modified data |
| snp_data_i | input | N_CORES*DATA_W | Per-core returned line data |
| mem_req_o | output | 1 | Memory request, held until mem_ack_i |
| mem_we_o | output | 1 | 1 = writeback, 0 = fill read |
| mem_addr_o | output | ADDR_W | Memory line address |
| mem_wdata_o | output | DATA_W | Writeback data |
| mem_ack_i | input | 1 | Memory completion strobe |
| mem_rdata_i | input | DATA_W | Fill data, valid with mem_ack_i |
| clean_cnt_o | output | CNT_W | Number of request snoops answered without data |
| dirty_cnt_o | output | CNT_W | Number of request snoops answered with modified data |

## Verification
The assertions assume three things about the inputs:
- A core acknowledges a snoop only while that snoop is raised toward it.
- Memory acknowledges only a pending request.
- A requester holds its request stable until it is granted.

The bench's core and memory models meet these assumptions. Each model answers with a single-cycle strobe only when it sees the matching request at a falling edge. Request tasks keep valid, kind and address fixed until the grant edge. The directed sequence drives reads, ownership requests, shared and modified holders, two chained evictions in one set and a same-line collision, so every snoop and writeback path is exercised from these well-formed responders.

// File: rtl/llc_sf_pkg.sv
package llc_sf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_SNP,
    ST_EVS,
    ST_WB,
    ST_FILL,
    ST_RESP
  } st_e;
endpackage

// File: rtl/llc_sf_arb.sv
module llc_sf_arb #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          en_i,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o
);
  logic found;

  // fixed priority, lowest index wins
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (en_i && req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/llc_sf_tags.sv
module llc_sf_tags #(
  parameter int N_CORES = 4,
  parameter int N_SETS  = 4,
  parameter int N_WAYS  = 2,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int WAY_W   = 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [ADDR_W-1:0]            lk_addr_i,
  output logic                         hit_o,
  output logic [WAY_W-1:0]             way_o,
  output logic                         e_vld_o,
  output logic                         e_dty_o,
  output logic [ADDR_W-$clog2(N_SETS)-1:0] e_tag_o,
  output logic [N_CORES-1:0]           e_msk_o,
  output logic [DATA_W-1:0]            e_dat_o,
  input  logic                         wr_i,
  input  logic [WAY_W-1:0]             wr_way_i,
  input  logic                         wr_alloc_i,
  input  logic                         wr_dty_i,
  input  logic [N_CORES-1:0]           wr_msk_i,
  input  logic [DATA_W-1:0]            wr_dat_i
);
  localparam int SET_W = $clog2(N_SETS);
  localparam int TAG_W = ADDR_W - SET_W;

  logic [N_WAYS-1:0]  vld_q [N_SETS];
  logic [N_WAYS-1:0]  dty_q [N_SETS];
  logic [TAG_W-1:0]   tag_q [N_SETS][N_WAYS];
  logic [N_CORES-1:0] msk_q [N_SETS][N_WAYS];
  logic [DATA_W-1:0]  dat_q [N_SETS][N_WAYS];
  logic [WAY_W-1:0]   rr_q  [N_SETS];

  logic [SET_W-1:0] set;
  logic [TAG_W-1:0] tag;
  logic [WAY_W-1:0] hway, vway;
  logic             vfound;

  assign set = lk_addr_i[SET_W-1:0];
  assign tag = lk_addr_i[ADDR_W-1:SET_W];

  always_comb begin
    hit_o  = 1'b0;
    hway   = '0;
    vway   = rr_q[set];
    vfound = 1'b0;
    for (int w = 0; w < N_WAYS; w++) begin
      if (vld_q[set][w] && tag_q[set][w] == tag) begin
        hit_o = 1'b1;
        hway  = WAY_W'(w);
      end
      if (!vld_q[set][w] && !vfound) begin
        vway   = WAY_W'(w);
        vfound = 1'b1;
      end
    end
  end

  assign way_o   = hit_o ? hway : vway;
  assign e_vld_o = vld_q[set][way_o];
  assign e_dty_o = dty_q[set][way_o];
  assign e_tag_o = tag_q[set][way_o];
  assign e_msk_o = msk_q[set][way_o];
  assign e_dat_o = dat_q[set][way_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < N_SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else if (wr_i) begin
      vld_q[set][wr_way_i] <= 1'b1;
      if (wr_alloc_i)
        rr_q[set] <= (rr_q[set] == WAY_W'(N_WAYS - 1)) ? '0 : rr_q[set] + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      dty_q[set][wr_way_i] <= wr_dty_i;
      tag_q[set][wr_way_i] <= tag;
      msk_q[set][wr_way_i] <= wr_msk_i;
      dat_q[set][wr_way_i] <= wr_dat_i;
    end
  end

  // R11: a miss never picks a valid way while an invalid one exists
  p_victim_free_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_o && vfound) |-> !vld_q[set][way_o]);
endmodule

// File: rtl/llc_sf_snoop.sv
module llc_sf_snoop #(
  parameter int N_CORES = 4,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [N_CORES-1:0]         tgt_i,
  input  logic                       count_i,
  input  logic [N_CORES-1:0]         ack_i,
  input  logic [N_CORES-1:0]         dirty_i,
  input  logic [N_CORES*DATA_W-1:0]  data_i,
  output logic [N_CORES-1:0]         pend_o,
  output logic                       done_o,
  output logic                       dirty_o,
  output logic [DATA_W-1:0]          data_o,
  output logic [CNT_W-1:0]           clean_cnt_o,
  output logic [CNT_W-1:0]           dirty_cnt_o
);
  logic               act_q, cnt_q, got_q;
  logic [N_CORES-1:0] pend_q, took;
  logic [DATA_W-1:0]  dat_q, cap_dat;
  logic [CNT_W-1:0]   clean_q, drt_q;
  logic               cap;
  int                 n_cl, n_dr;

  assign took = ack_i & pend_q;

  always_comb begin
    cap     = 1'b0;
    cap_dat = '0;
    n_cl    = 0;
    n_dr    = 0;
    for (int i = 0; i < N_CORES; i++) begin
      if (took[i]) begin
        if (dirty_i[i]) begin
          n_dr++;
          cap     = 1'b1;
          cap_dat = data_i[i*DATA_W +: DATA_W];
        end else begin
          n_cl++;
        end
      end
    end
  end

  assign done_o = act_q && (pend_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      cnt_q   <= 1'b0;
      got_q   <= 1'b0;
      pend_q  <= '0;
      dat_q   <= '0;
      clean_q <= '0;
      drt_q   <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      cnt_q  <= count_i;
      got_q  <= 1'b0;
      pend_q <= tgt_i;
    end else begin
      pend_q <= pend_q & ~ack_i;
      if (cap) begin
        got_q <= 1'b1;
        dat_q <= cap_dat;
      end
      if (done_o) act_q <= 1'b0;
      if (act_q && cnt_q) begin
        clean_q <= clean_q + CNT_W'(n_cl);
        drt_q   <= drt_q + CNT_W'(n_dr);
      end
    end
  end

  assign pend_o      = pend_q;
  assign dirty_o     = got_q;
  assign data_o      = dat_q;
  assign clean_cnt_o = clean_q;
  assign dirty_cnt_o = drt_q;

  // R4: outstanding snoop targets only ever shrink between starts
  p_pend_shrink_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ((pend_q & ~$past(pend_q)) == '0));
  // R9: a new snoop round never starts over a running one
  p_start_when_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !act_q);
endmodule

// File: rtl/llc_snoop_filter.sv
module llc_snoop_filter
  import llc_sf_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int N_SETS  = 4,
  parameter int N_WAYS  = 2,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_CORES-1:0]        req_valid_i,
  input  logic [N_CORES-1:0]        req_write_i,
  input  logic [N_CORES*ADDR_W-1:0] req_addr_i,
  output logic [N_CORES-1:0]        req_ready_o,
  output logic [N_CORES-1:0]        resp_valid_o,
  output logic [DATA_W-1:0]         resp_data_o,
  output logic [N_CORES-1:0]        snp_valid_o,
  output logic                      snp_inv_o,
  output logic [ADDR_W-1:0]         snp_addr_o,
  input  logic [N_CORES-1:0]        snp_ack_i,
  input  logic [N_CORES-1:0]        snp_dirty_i,
  input  logic [N_CORES*DATA_W-1:0] snp_data_i,
  output logic                      mem_req_o,
  output logic                      mem_we_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic [DATA_W-1:0]         mem_wdata_o,
  input  logic                      mem_ack_i,
  input  logic [DATA_W-1:0]         mem_rdata_i,
  output logic [CNT_W-1:0]          clean_cnt_o,
  output logic [CNT_W-1:0]          dirty_cnt_o
);
  localparam int SET_W  = $clog2(N_SETS);
  localparam int TAG_W  = ADDR_W - SET_W;
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;
  localparam int WAY_W  = (N_WAYS > 1) ? $clog2(N_WAYS) : 1;

  st_e                st_q;
  logic [CORE_W-1:0]  core_q, gnt_idx;
  logic [N_CORES-1:0] gnt, req_bit, others;
  logic               wr_q, alloc_q, snp_inv_q;
  logic [ADDR_W-1:0]  addr_q, vaddr_q, snp_addr_q;
  logic [WAY_W-1:0]   way_q;
  logic               w_dty_q;
  logic [N_CORES-1:0] w_msk_q;
  logic [DATA_W-1:0]  w_dat_q;

  logic               hit, e_vld, e_dty;
  logic [WAY_W-1:0]   way;
  logic [TAG_W-1:0]   e_tag;
  logic [N_CORES-1:0] e_msk, tag_msk;
  logic [DATA_W-1:0]  e_dat;

  logic               snp_start, snp_count, snp_done, snp_dirty;
  logic [N_CORES-1:0] snp_tgt;
  logic [DATA_W-1:0]  snp_dat;

  llc_sf_arb #(.N(N_CORES), .IW(CORE_W)) u_arb (
    .en_i  (st_q == ST_IDLE),
    .req_i (req_valid_i),
    .gnt_o (gnt),
    .idx_o (gnt_idx)
  );

  llc_sf_tags #(
    .N_CORES(N_CORES), .N_SETS(N_SETS), .N_WAYS(N_WAYS),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_addr_i  (addr_q),
    .hit_o      (hit),
    .way_o      (way),
    .e_vld_o    (e_vld),
    .e_dty_o    (e_dty),
    .e_tag_o    (e_tag),
    .e_msk_o    (e_msk),
    .e_dat_o    (e_dat),
    .wr_i       (st_q == ST_RESP),
    .wr_way_i   (way_q),
    .wr_alloc_i (alloc_q),
    .wr_dty_i   (w_dty_q),
    .wr_msk_i   (tag_msk),
    .wr_dat_i   (w_dat_q)
  );

  llc_sf_snoop #(.N_CORES(N_CORES), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_snoop (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (snp_start),
    .tgt_i       (snp_tgt),
    .count_i     (snp_count),
    .ack_i       (snp_ack_i),
    .dirty_i     (snp_dirty_i),
    .data_i      (snp_data_i),
    .pend_o      (snp_valid_o),
    .done_o      (snp_done),
    .dirty_o     (snp_dirty),
    .data_o      (snp_dat),
    .clean_cnt_o (clean_cnt_o),
    .dirty_cnt_o (dirty_cnt_o)
  );

  assign req_bit = N_CORES'(1) << core_q;
  assign others  = e_msk & ~req_bit;
  // ownership leaves only the requester; a read joins the sharers
  assign tag_msk = wr_q ? req_bit : (w_msk_q | req_bit);

  always_comb begin
    snp_start = 1'b0;
    snp_tgt   = '0;
    snp_count = 1'b0;
    if (st_q == ST_LOOK) begin
      if (hit) begin
        if (|others) begin
          snp_start = 1'b1;
          snp_tgt   = others;
          snp_count = 1'b1;
        end
      end else if (e_vld && (|e_msk)) begin
        snp_start = 1'b1;
        snp_tgt   = e_msk;
      end
    end
  end

  assign req_ready_o  = gnt;
  assign resp_valid_o = (st_q == ST_RESP) ? req_bit : '0;
  assign resp_data_o  = w_dat_q;
  assign snp_inv_o    = snp_inv_q;
  assign snp_addr_o   = snp_addr_q;
  assign mem_req_o    = (st_q == ST_WB) || (st_q == ST_FILL);
  assign mem_we_o     = (st_q == ST_WB);
  assign mem_addr_o   = mem_we_o ? vaddr_q : addr_q;
  assign mem_wdata_o  = w_dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      core_q     <= '0;
      wr_q       <= 1'b0;
      addr_q     <= '0;
      vaddr_q    <= '0;
      snp_addr_q <= '0;
      snp_inv_q  <= 1'b0;
      way_q      <= '0;
      alloc_q    <= 1'b0;
      w_dty_q    <= 1'b0;
      w_msk_q    <= '0;
      w_dat_q    <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (|gnt) begin
          core_q <= gnt_idx;
          wr_q   <= req_write_i[gnt_idx];
          addr_q <= req_addr_i[gnt_idx*ADDR_W +: ADDR_W];
          st_q   <= ST_LOOK;
        end
        ST_LOOK: begin
          way_q   <= way;
          w_dty_q <= e_dty;
          w_msk_q <= e_msk;
          w_dat_q <= e_dat;
          alloc_q <= !hit;
          vaddr_q <= {e_tag, addr_q[SET_W-1:0]};
          if (hit) begin
            snp_addr_q <= addr_q;
            snp_inv_q  <= wr_q;
            st_q       <= (|others) ? ST_SNP : ST_RESP;
          end else begin
            snp_addr_q <= {e_tag, addr_q[SET_W-1:0]};
            snp_inv_q  <= 1'b1;
            if (e_vld && (|e_msk))  st_q <= ST_EVS;
            else if (e_vld && e_dty) st_q <= ST_WB;
            else                     st_q <= ST_FILL;
          end
        end
        ST_SNP: if (snp_done) begin
          if (snp_dirty) begin
            w_dat_q <= snp_dat;
            w_dty_q <= 1'b1;
          end
          st_q <= ST_RESP;
        end
        ST_EVS: if (snp_done) begin
          if (snp_dirty) w_dat_q <= snp_dat;
          w_msk_q <= '0;
          st_q    <= (w_dty_q || snp_dirty) ? ST_WB : ST_FILL;
        end
        ST_WB: if (mem_ack_i) begin
          w_dty_q <= 1'b0;
          st_q    <= ST_FILL;
        end
        ST_FILL: if (mem_ack_i) begin
          w_dat_q <= mem_rdata_i;
          w_dty_q <= 1'b0;
          w_msk_q <= '0;
          st_q    <= ST_RESP;
        end
        ST_RESP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9: at most one grant, and none while a transaction is open
  p_one_grant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o));
  p_no_regrant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_ready_o) |=> (req_ready_o == '0));
  // R3: one response strobe at a time
  p_resp_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(resp_valid_o));
  // R4: the requester is never snooped for its own request
  p_no_self_snoop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SNP) |-> !(|(snp_valid_o & req_bit)));
  // R2: no core snoop is outstanding while a fill is requested
  p_fill_no_snoop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (snp_valid_o == '0));
  // R8: writeback only after the back-invalidate round has drained
  p_wb_after_evict_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (snp_valid_o == '0));
endmodule

// File: tb/llc_snoop_filter_bench.sv
`timescale 1ns/100ps
module llc_snoop_filter_bench;
  localparam int NC = 4;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NC-1:0]    req_valid = '0, req_write = '0;
  logic [NC*AW-1:0] req_addr = '0;
  logic [NC-1:0]    req_ready, resp_valid, snp_valid;
  logic [DW-1:0]    resp_data;
  logic             snp_inv;
  logic [AW-1:0]    snp_addr;
  logic [NC-1:0]    snp_ack = '0, snp_dirty = '0;
  logic [NC*DW-1:0] snp_data = '0;
  logic             mem_req, mem_we;
  logic [AW-1:0]    mem_addr;
  logic [DW-1:0]    mem_wdata;
  logic             mem_ack = 1'b0;
  logic [DW-1:0]    mem_rdata = '0;
  logic [CW-1:0]    clean_cnt, dirty_cnt;

  llc_snoop_filter u_llc_snoop_filter (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_ready_o(req_ready), .resp_valid_o(resp_valid), .resp_data_o(resp_data),
    .snp_valid_o(snp_valid), .snp_inv_o(snp_inv), .snp_addr_o(snp_addr),
    .snp_ack_i(snp_ack), .snp_dirty_i(snp_dirty), .snp_data_i(snp_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .clean_cnt_o(clean_cnt), .dirty_cnt_o(dirty_cnt)
  );

  int n_tests = 0, n_fail = 0;
  logic done = 1'b0;

  logic          cv [NC][256];
  logic          cm [NC][256];
  logic [DW-1:0] cd [NC][256];
  logic [DW-1:0] mem [256];

  int            snp_n [NC];
  logic          snp_kind [NC];
  int            n_rd, n_wr, wr_at_rd, rd_at_snp, ord_n;
  int            ord [4];
  logic [AW-1:0] wr_addr_seen;
  logic [DW-1:0] wr_data_seen;

  function automatic logic [DW-1:0] minit(logic [7:0] a);
    return {a, ~a};
  endfunction

  function automatic logic [DW-1:0] wval(int c, logic [7:0] a);
    return {4'hC, 4'(c), a};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    for (int c = 0; c < NC; c++) begin
      snp_n[c] = 0;
      snp_kind[c] = 1'b0;
    end
    n_rd = 0; n_wr = 0; wr_at_rd = -1; rd_at_snp = -1; ord_n = 0;
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin
      mem[a] = minit(8'(a));
      for (int c = 0; c < NC; c++) begin
        cv[c][a] = 1'b0; cm[c][a] = 1'b0; cd[c][a] = '0;
      end
    end
    clear_mon();
  end

  // core cache models answer snoops
  initial forever begin
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      if (snp_valid[c] && !snp_ack[c]) begin
        snp_ack[c]   = 1'b1;
        snp_dirty[c] = cv[c][snp_addr] && cm[c][snp_addr];
        snp_data[c*DW +: DW] = cd[c][snp_addr];
        snp_n[c]++;
        snp_kind[c] = snp_inv;
        rd_at_snp   = n_rd;
        if (snp_inv) cv[c][snp_addr] = 1'b0;
        cm[c][snp_addr] = 1'b0;
      end else begin
        snp_ack[c] = 1'b0;
      end
    end
  end

  // memory model with inclusion monitor
  initial forever begin
    @(negedge clk);
    if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        n_wr++;
        wr_addr_seen = mem_addr;
        wr_data_seen = mem_wdata;
      end else begin
        mem_rdata = mem[mem_addr];
        n_rd++;
        wr_at_rd = n_wr;
        for (int c = 0; c < NC; c++)
          check("R10 fill of a line held by a core", 32'(cv[c][mem_addr]), 0);
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk);
    for (int c = 0; c < NC; c++)
      if (resp_valid[c]) begin
        if (ord_n < 4) ord[ord_n] = c;
        ord_n++;
      end
  end

  task automatic do_req(input int c, input logic [7:0] a, input logic wr,
                        output logic [DW-1:0] data);
    @(negedge clk);
    req_valid[c] = 1'b1;
    req_write[c] = wr;
    req_addr[c*AW +: AW] = a;
    #1;
    while (!req_ready[c]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid[c] = 1'b0;
    @(negedge clk);
    while (!resp_valid[c]) @(negedge clk);
    data = resp_data;
    cv[c][a] = 1'b1;
    cm[c][a] = wr;
    cd[c][a] = wr ? wval(c, a) : data;
    @(posedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 ready", 32'(req_ready), 0);
    check("R1 resp", 32'(resp_valid), 0);
    check("R1 snoop", 32'(snp_valid), 0);
    check("R1 mem_req", 32'(mem_req), 0);
    check("R1 clean count", 32'(clean_cnt), 0);
    check("R1 dirty count", 32'(dirty_cnt), 0);
  endtask

  task automatic t_miss();
    logic [DW-1:0] d;
    clear_mon();
    do_req(0, 8'h10, 1'b0, d);
    check("R2 miss data", 32'(d), 32'(minit(8'h10)));
    check("R2 one memory read", n_rd, 1);
    check("R2 no snoops", snp_n[0] + snp_n[1] + snp_n[2] + snp_n[3], 0);
  endtask

  task automatic t_hit_own();
    logic [DW-1:0] d;
    clear_mon();
    do_req(0, 8'h10, 1'b0, d);
    check("R3 direct hit data", 32'(d), 32'(minit(8'h10)));
    check("R3 no memory", n_rd + n_wr, 0);
    check("R3 no snoops", snp_n[0] + snp_n[1] + snp_n[2] + snp_n[3], 0);
  endtask

  task automatic t_shared();
    logic [DW-1:0] d;
    clear_mon();
    do_req(1, 8'h10, 1'b0, d);
    check("R4 share snoop core0", snp_n[0], 1);
    check("R4 share kind", 32'(snp_kind[0]), 0);
    check("R4 no snoop to others", snp_n[1] + snp_n[2] + snp_n[3], 0);
    check("R4 data", 32'(d), 32'(minit(8'h10)));
    check("R7 clean count", 32'(clean_cnt), 1);
    clear_mon();
    do_req(2, 8'h10, 1'b1, d);
    check("R4 requester bit added: core1 snooped", snp_n[1], 1);
    check("R5 invalidate core0", snp_n[0], 1);
    check("R5 invalidate kind", 32'(snp_kind[0] & snp_kind[1]), 1);
    check("R5 no self snoop", snp_n[2] + snp_n[3], 0);
    check("R7 clean count after write", 32'(clean_cnt), 3);
  endtask

  task automatic t_dirty_fwd();
    logic [DW-1:0] d;
    clear_mon();
    do_req(3, 8'h10, 1'b0, d);
    check("R5 only owner snooped", snp_n[0] + snp_n[1] + snp_n[3], 0);
    check("R5 owner snooped once", snp_n[2], 1);
    check("R6 forwarded modified data", 32'(d), 32'(wval(2, 8'h10)));
    check("R7 dirty count", 32'(dirty_cnt), 1);
    clear_mon();
    do_req(0, 8'h10, 1'b0, d);
    check("R6 LLC holds updated data", 32'(d), 32'(wval(2, 8'h10)));
    check("R4 both sharers snooped", snp_n[2] + snp_n[3], 2);
    check("R7 clean count sharers", 32'(clean_cnt), 5);
    check("R3 no memory on hit", n_rd, 0);
  endtask

  task automatic t_evict();
    logic [DW-1:0] d;
    do_req(1, 8'h22, 1'b1, d);
    do_req(2, 8'h26, 1'b1, d);
    clear_mon();
    do_req(3, 8'h2A, 1'b0, d);
    check("R8 back-invalidate holder", snp_n[1], 1);
    check("R8 invalidate kind", 32'(snp_kind[1]), 1);
    check("R11 victim is oldest way", snp_n[2], 0);
    check("R8 snoop before fill", rd_at_snp, 0);
    check("R8 one writeback", n_wr, 1);
    check("R8 writeback address", 32'(wr_addr_seen), 32'h22);
    check("R6 writeback data", 32'(wr_data_seen), 32'(wval(1, 8'h22)));
    check("R8 writeback before fill", wr_at_rd, 1);
    check("R8 fill data", 32'(d), 32'(minit(8'h2A)));
    check("R8 core copy dropped", 32'(cv[1][8'h22]), 0);
    check("R7 evictions not counted", 32'({clean_cnt, dirty_cnt}), 32'({16'd5, 16'd1}));
    clear_mon();
    do_req(1, 8'h22, 1'b0, d);
    check("R11 round-robin victim core2 line", snp_n[2], 1);
    check("R6 written-back data refetched", 32'(d), 32'(wval(1, 8'h22)));
    check("R8 second writeback address", 32'(wr_addr_seen), 32'h26);
  endtask

  task automatic t_serial();
    logic [DW-1:0] d1, d3;
    clear_mon();
    fork
      do_req(3, 8'h30, 1'b0, d3);
      do_req(1, 8'h30, 1'b0, d1);
    join
    check("R9 response count", ord_n, 2);
    check("R9 lower core first", ord[0], 1);
    check("R9 other core second", ord[1], 3);
    check("R9 single fill for same line", n_rd, 1);
    check("R9 second request snoops first holder", snp_n[1], 1);
    check("R9 both data", 32'({d1, d3}), 32'({minit(8'h30), minit(8'h30)}));
    check("R7 clean count", 32'(clean_cnt), 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_miss();
    t_hit_own();
    t_shared();
    t_dirty_fwd();
    t_evict();
    t_serial();
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R9 watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule